// File: doc/BRIEF.md
# Hardware Kick Dispatcher and Busy Tracker

This block sits beside a small accumulator CPU and looks at every 32-bit instruction word the CPU issues. Words whose opcode marks them as hardware kicks are sent to one of several dedicated pipelines. The pipeline receives a one-cycle start strobe and a control-stream base address, which is read from the general register named in the instruction. Kicks do not hold up the CPU. Several pipelines can run at once, but each pipeline accepts only one kick at a time.

The block keeps a busy bit for each pipeline. A second kick to a pipeline that is still running, and the barrier instruction while any pipeline is still running, both raise a combinational stall. The CPU keeps presenting the same word until the stall drops. A pipeline clears its busy bit with a single-cycle done pulse. A done pulse counts in the same cycle it arrives, so a waiting kick or barrier can go ahead in that cycle.

Top module: `kick_dispatch`

## Requirements
- R1: The opcode is `instr_i[7:0]`. Bit 0 set means a hardware kick, and `instr_i[3:1]` then selects the pipeline. `rf_raddr_o` always equals `instr_i[10:8]`, the general-register index.
- R2: A kick issued to an idle pipeline p raises `start_o[p]` for the next cycle only. In that cycle `base_o` equals the register data present at issue. The kick does not stall.
- R3: A kick issued to a pipeline that is busy and has no done pulse in the same cycle raises `stall_o` in that cycle. No start follows.
- R4: A done pulse and a kick to the same busy pipeline in the same cycle give no stall, and the start follows. The pipeline then stays busy, so a further kick to it stalls.
- R5: The barrier opcode 8'h02 stalls while any pipeline is busy without a done pulse in that cycle. With no pipeline busy, it does not stall.
- R6: A kick whose pipeline index is NUM_PIPES or higher (4 to 7 by default) starts nothing, never stalls and leaves every busy bit unchanged.
- R7: An instruction with opcode bit 0 clear, other than the barrier, never stalls and starts nothing.
- R8: After reset every `start_o` bit is low, `stall_o` is low and all pipelines are idle.
- R9: While `issue_i` is low the word has no effect: no start and no stall.
- R10: A kick to an idle pipeline is not stalled while other pipelines are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word presented by the CPU |
| issue_i | input | 1 | The CPU issues `instr_i` this cycle |
| rf_raddr_o | output | 3 | Register-file read index |
| rf_rdata_i | input | ADDR_W | Register-file read data for `rf_raddr_o` |
| done_i | input | NUM_PIPES | Per-pipeline completion pulses |
| start_o | output | NUM_PIPES | Per-pipeline start strobes |
| base_o | output | ADDR_W | Control-stream base address, valid with a start |
| stall_o | output | 1 | Hold the CPU on the current word |

## Verification
A pipeline's done pulse can arrive in the same cycle as a new kick to that pipeline. It can also arrive in the same cycle as a barrier that is waiting on it. The bench provokes the first case with a kick held on a busy pipeline and a done pulse added in one cycle. It provokes the second with a barrier held while the last busy pipelines finish together. Random stimulus also drops done pulses onto busy pipelines at arbitrary points. In each case the bench judges against its own busy model: no stall in that cycle, a start in the next cycle for the kick, and the pipeline still busy afterwards.

// File: rtl/kd_pkg.sv
package kd_pkg;
  localparam int          REG_IDX_W = 3;
  localparam logic [7:0]  OPC_BARRIER = 8'h02;

  typedef enum logic [1:0] {
    KIND_CPU     = 2'd0,
    KIND_KICK    = 2'd1,
    KIND_BARRIER = 2'd2
  } word_kind_e;

  // Class of a word from its opcode byte.
  function automatic word_kind_e classify(input logic [7:0] opc);
    if (opc[0])                 return KIND_KICK;
    else if (opc == OPC_BARRIER) return KIND_BARRIER;
    else                        return KIND_CPU;
  endfunction

  // Pipeline index carried by a kick word.
  function automatic logic [2:0] pipe_field(input logic [7:0] opc);
    return opc[3:1];
  endfunction

  // General-register index in the second byte.
  function automatic logic [REG_IDX_W-1:0] reg_field(input logic [7:0] op2);
    return op2[REG_IDX_W-1:0];
  endfunction
endpackage

// File: rtl/kd_decode.sv
module kd_decode #(
  parameter int NUM_PIPES = 4
) (
  input  logic [15:0]                 word_lo,
  input  logic                        issue,
  output logic [NUM_PIPES-1:0]        kick_want,
  output logic                        barrier_req,
  output logic [kd_pkg::REG_IDX_W-1:0] reg_idx
);
  import kd_pkg::*;

  word_kind_e kind;
  logic [2:0] pidx;

  always_comb begin
    kind        = classify(word_lo[7:0]);
    pidx        = pipe_field(word_lo[7:0]);
    reg_idx     = reg_field(word_lo[15:8]);
    barrier_req = issue && (kind == KIND_BARRIER);
  end

  // One select line per implemented pipeline; higher indices match none.
  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_sel
    assign kick_want[g] = issue && (kind == KIND_KICK) && (pidx == 3'(g));
  end
endmodule

// File: rtl/kd_tracker.sv
module kd_tracker #(
  parameter int NUM_PIPES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] launch,
  input  logic [NUM_PIPES-1:0] done,
  output logic [NUM_PIPES-1:0] busy,
  output logic [NUM_PIPES-1:0] pending
);
  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    logic busy_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         busy_q <= 1'b0;
      else if (launch[g]) busy_q <= 1'b1;   // a launch wins over a done
      else if (done[g])   busy_q <= 1'b0;
    end
    assign busy[g]    = busy_q;
    assign pending[g] = busy_q && !done[g];
  end
endmodule

// File: rtl/kd_launch.sv
module kd_launch #(
  parameter int NUM_PIPES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] launch,
  input  logic [ADDR_W-1:0]    addr_in,
  output logic [NUM_PIPES-1:0] start,
  output logic [ADDR_W-1:0]    base
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start <= '0;
      base  <= '0;
    end else begin
      start <= launch;
      if (|launch) base <= addr_in;
    end
  end
endmodule

// File: rtl/kick_dispatch.sv
module kick_dispatch #(
  parameter int NUM_PIPES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [31:0]                   instr_i,
  input  logic                          issue_i,
  output logic [kd_pkg::REG_IDX_W-1:0]  rf_raddr_o,
  input  logic [ADDR_W-1:0]             rf_rdata_i,
  input  logic [NUM_PIPES-1:0]          done_i,
  output logic [NUM_PIPES-1:0]          start_o,
  output logic [ADDR_W-1:0]             base_o,
  output logic                          stall_o
);
  // Named internal events, observed by the bound checker.
  logic [NUM_PIPES-1:0] kick_want;
  logic [NUM_PIPES-1:0] busy_w;
  logic [NUM_PIPES-1:0] pending_w;
  logic [NUM_PIPES-1:0] launch_w;
  logic [NUM_PIPES-1:0] kick_held;
  logic                 barrier_req;
  logic                 barrier_held;
  logic [15:0]          word_lo;

  assign word_lo = instr_i[15:0];

  kd_decode #(.NUM_PIPES(NUM_PIPES)) u_dec (
    .word_lo     (word_lo),
    .issue       (issue_i),
    .kick_want   (kick_want),
    .barrier_req (barrier_req),
    .reg_idx     (rf_raddr_o)
  );

  kd_tracker #(.NUM_PIPES(NUM_PIPES)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch_w),
    .done    (done_i),
    .busy    (busy_w),
    .pending (pending_w)
  );

  assign kick_held    = kick_want & pending_w;
  assign launch_w     = kick_want & ~pending_w;
  assign barrier_held = barrier_req && (|pending_w);
  assign stall_o      = (|kick_held) || barrier_held;

  kd_launch #(.NUM_PIPES(NUM_PIPES), .ADDR_W(ADDR_W)) u_lch (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (launch_w),
    .addr_in (rf_rdata_i),
    .start   (start_o),
    .base    (base_o)
  );
endmodule

// File: rtl/kick_dispatch_chk.sv
module kick_dispatch_chk #(
  parameter int NUM_PIPES = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [31:0]          instr_i,
  input logic                 issue_i,
  input logic [NUM_PIPES-1:0] done_i,
  input logic [NUM_PIPES-1:0] start_o,
  input logic                 stall_o,
  input logic [NUM_PIPES-1:0] busy_w
);
  // R1: one instruction launches at most one pipeline
  a_r1_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_o));

  // R2: a started pipeline reads as busy while its strobe is high
  a_r2_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o != '0) |-> ((start_o & ~busy_w) == '0));

  // R3: a stalled cycle launches nothing
  a_r3_stall_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> (start_o == '0));

  // R5: barrier with an unfinished pipeline must stall
  a_r5_barrier_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i[7:0] == 8'h02 && (busy_w & ~done_i) != '0) |-> stall_o);

  // R7: plain CPU words never stall
  a_r7_cpu_free: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !instr_i[0] && instr_i[7:0] != 8'h02) |-> !stall_o);

  // R9: no issue, no start and no stall
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |-> (!stall_o ##1 start_o == '0));

  // R4: busy drops only through a done pulse
  a_r4_busy_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    ((busy_w & ~done_i) != '0) |=> (($past(busy_w & ~done_i) & ~busy_w) == '0));
endmodule

bind kick_dispatch kick_dispatch_chk #(.NUM_PIPES(NUM_PIPES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .instr_i (instr_i),
  .issue_i (issue_i),
  .done_i  (done_i),
  .start_o (start_o),
  .stall_o (stall_o),
  .busy_w  (busy_w)
);

// File: tb/kick_dispatch_test.sv
`timescale 1ns/1ps
module kick_dispatch_test;
  localparam int N  = 4;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [31:0]   instr;
  logic          issue;
  logic [2:0]    raddr;
  logic [AW-1:0] rdata;
  logic [N-1:0]  done;
  logic [N-1:0]  start;
  logic [AW-1:0] base;
  logic          stall;

  logic [AW-1:0] regs [8];
  logic [N-1:0]  busy_m;
  int            n_vec = 0;
  int            n_bad = 0;

  always #4 clk = ~clk;
  assign rdata = regs[raddr];

  kick_dispatch #(.NUM_PIPES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .issue_i(issue),
    .rf_raddr_o(raddr), .rf_rdata_i(rdata), .done_i(done),
    .start_o(start), .base_o(base), .stall_o(stall)
  );

  function automatic logic [31:0] kick_word(input int p, input int r);
    return {21'd0, 3'(r), 4'd0, 3'(p), 1'b1};
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // One cycle: drive, check combinational outputs, clock, check registered ones.
  task automatic step(input logic [31:0] w, input logic iss, input logic [N-1:0] dn,
                      input string tag);
    logic [N-1:0] pend, fire;
    logic         exp_stall;
    logic [AW-1:0] exp_base;
    int p;
    @(negedge clk);
    instr = w; issue = iss; done = dn;
    #1;
    pend = busy_m & ~dn;
    p = int'(w[3:1]);
    fire = '0;
    exp_stall = 1'b0;
    if (iss && w[0] && p < N) begin
      if (pend[p]) exp_stall = 1'b1;
      else         fire[p] = 1'b1;
    end
    if (iss && w[7:0] == 8'h02 && pend != '0) exp_stall = 1'b1;
    exp_base = regs[w[10:8]];
    check({tag, " R1 raddr"}, 64'(raddr), 64'(w[10:8]));
    check({tag, " stall"}, 64'(stall), 64'(exp_stall));
    @(posedge clk); #1;
    check({tag, " R2 start"}, 64'(start), 64'(fire));
    if (fire != '0) check({tag, " R2 base"}, 64'(base), 64'(exp_base));
    busy_m = pend | fire;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) regs[i] = $urandom;
    regs[3] = 32'hCAFE_0003;
    busy_m = '0;
    rst_n = 1'b0; instr = '0; issue = 1'b0; done = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R8 start after reset", 64'(start), 64'd0);
    check("R8 stall after reset", 64'(stall), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    step(kick_word(0, 3), 1, '0, "R8 first kick");
    step(kick_word(1, 5), 1, '0, "R10 concurrent");
    step(kick_word(0, 2), 1, '0, "R3 busy kick");
    step(kick_word(0, 2), 1, 4'b0001, "R4 done+kick");
    step(kick_word(0, 2), 1, '0, "R4 still busy");
    step(kick_word(5, 1), 1, '0, "R6 unimpl");
    step(32'h0000_0002, 1, '0, "R5 barrier waits");
    step(32'h0000_0002, 1, 4'b0011, "R5 barrier releases");
    step(32'h0000_0002, 1, '0, "R5 barrier idle");
    step(kick_word(2, 1), 0, '0, "R9 no issue");
    step(kick_word(2, 7), 1, '0, "R1 reg index");
    step(32'h0000_07A4, 1, '0, "R7 cpu op");
    step(kick_word(7, 0), 1, '0, "R6 top index");
    step(kick_word(2, 0), 1, 4'b0100, "R4 release kick");
    step(32'h0000_0000, 1, 4'b0100, "R7 drain");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      logic [N-1:0] dn;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 5)       w = kick_word(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      else if (sel < 7)  w = 32'h0000_0002 | ({$urandom} & 32'hFFFF_FF00);
      else               w = {$urandom} & 32'hFFFF_FFFE;
      dn = N'($urandom) & busy_m;
      if (($urandom & 3) == 0) regs[$urandom_range(0, 7)] = $urandom;
      step(w, 1'($urandom_range(0, 7) != 0), dn, "R2 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule